// File: doc/BRIEF.md
# Dual-Mode Display RAM Address Counter

This block supplies the write pointer for a one-bit-per-pixel display memory organised as 6 banks of 84 byte-wide columns, where each bank holds 8 pixel rows. It keeps a 7-bit column pointer and a 3-bit bank pointer. Each pointer can be loaded on its own by a strobe. A scan-mode bit decides how the pointer moves after each data byte. In horizontal scan it runs across the columns and then moves to the next bank. In vertical scan it runs down the banks and then moves to the next column.

Each data-byte write is forwarded to the memory one cycle later as a registered strobe. The strobe carries the column, the bank and the first pixel row of the bank that the byte lands on. A load, or a mode change, that arrives in the same cycle as a write takes effect before that write. A load value outside the legal range is dropped in the default build, so the pointers never leave the grid. The memory array and the command decoder that produces the strobes sit outside this block.

Top module: `disp_addr_ctr`

## Requirements
- R1: The column pointer always stays within 0..83 and the bank pointer always stays within 0..5.
- R2: In horizontal scan (scan bit 0), a write advances the column pointer by one. Going past column 83 returns the column to 0 and advances the bank by one.
- R3: In vertical scan (scan bit 1), a write advances the bank pointer by one. Going past bank 5 returns the bank to 0 and advances the column by one.
- R4: A write at column 83, bank 5 returns both pointers to 0 in either scan mode.
- R5: A column load changes only the column pointer, and a bank load changes only the bank pointer. Both loads can happen in the same cycle.
- R6: Synchronous reset sets both pointers to 0, selects horizontal scan and clears the write strobe.
- R7: A write accepted at a clock edge raises `wr_en` for exactly the next cycle. In that cycle `wr_col` and `wr_bank` show the location written, and `wr_row` shows 8 × bank, the top pixel row of the eight rows the bank covers.
- R8: A load or a scan-mode change in the same cycle as a write applies first. The byte goes to the loaded location, and the pointer then advances from there under the new mode.
- R9: With the default `CLAMP_LOADS = 0`, a column load above 83 or a bank load above 5 is ignored and the pointer keeps its value. A legal load of the other pointer in the same cycle still applies.
- R10: A mode strobe stores `mode_val` (0 horizontal, 1 vertical). The value is visible on `vert_mode` and holds until the next mode strobe or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_wr | input | 1 | A data byte is written this cycle |
| col_ld | input | 1 | Load the column pointer from `col_val` |
| col_val | input | 7 | Column load value |
| bank_ld | input | 1 | Load the bank pointer from `bank_val` |
| bank_val | input | 3 | Bank load value |
| mode_ld | input | 1 | Load the scan mode from `mode_val` |
| mode_val | input | 1 | Scan mode: 0 horizontal, 1 vertical |
| col_ptr | output | 7 | Current column pointer |
| bank_ptr | output | 3 | Current bank pointer |
| vert_mode | output | 1 | Current scan mode |
| wr_en | output | 1 | Registered write strobe toward the memory |
| wr_col | output | 7 | Column of the registered write |
| wr_bank | output | 3 | Bank of the registered write |
| wr_row | output | 6 | First pixel row of the written bank |

## Verification
The step and wrap properties take for granted that no load strobe is present in the same cycle. This holds because a load redirects the pointer before it advances. The out-of-range property likewise expects no write in that cycle. The bench keeps to these conditions by driving a load, a mode change or a write in separate cycles, except in the scenarios that deliberately combine them to exercise R8. Those combined cases are checked by the bench against computed addresses, not by the stepping properties. All stimulus changes on the falling clock edge, so every strobe is a clean single-cycle pulse.

// File: rtl/disp_addr_pkg.sv
package disp_addr_pkg;

    typedef enum logic {
        SCAN_HORIZ = 1'b0,
        SCAN_VERT  = 1'b1
    } scan_mode_t;

    typedef struct packed {
        logic [15:0] col;
        logic [15:0] bank;
    } grid_pos_t;

    function automatic logic is_last(input logic [15:0] v, input logic [15:0] last);
        return v == last;
    endfunction

    function automatic logic [15:0] wrap_bump(input logic [15:0] v, input logic [15:0] last);
        return (v == last) ? 16'd0 : v + 16'd1;
    endfunction

    function automatic logic [15:0] clamp_to(input logic [15:0] v, input logic [15:0] last);
        return (v > last) ? last : v;
    endfunction

endpackage

// File: rtl/dac_load_sel.sv
module dac_load_sel
    import disp_addr_pkg::*;
#(
    parameter int NUM_COLS    = 84,
    parameter int NUM_BANKS   = 6,
    parameter int CLAMP_LOADS = 0,
    parameter int COL_W       = $clog2(NUM_COLS),
    parameter int BANK_W      = $clog2(NUM_BANKS)
) (
    input  logic [COL_W-1:0]  cur_col,
    input  logic [BANK_W-1:0] cur_bank,
    input  logic              col_ld,
    input  logic [COL_W-1:0]  col_val,
    input  logic              bank_ld,
    input  logic [BANK_W-1:0] bank_val,
    output logic [COL_W-1:0]  eff_col,
    output logic [BANK_W-1:0] eff_bank
);
    localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(NUM_COLS - 1);
    localparam logic [BANK_W-1:0] BANK_LAST = BANK_W'(NUM_BANKS - 1);

    grid_pos_t req;

    always_comb begin
        req.col  = 16'(col_val);
        req.bank = 16'(bank_val);
    end

    generate
        if (CLAMP_LOADS != 0) begin : g_clamp
            always_comb begin
                eff_col  = col_ld  ? COL_W'(clamp_to(req.col, 16'(COL_LAST)))    : cur_col;
                eff_bank = bank_ld ? BANK_W'(clamp_to(req.bank, 16'(BANK_LAST))) : cur_bank;
            end
        end else begin : g_ignore
            always_comb begin
                eff_col  = (col_ld  && (col_val  <= COL_LAST))  ? col_val  : cur_col;
                eff_bank = (bank_ld && (bank_val <= BANK_LAST)) ? bank_val : cur_bank;
            end
        end
    endgenerate

endmodule

// File: rtl/dac_step.sv
module dac_step
    import disp_addr_pkg::*;
#(
    parameter int NUM_COLS  = 84,
    parameter int NUM_BANKS = 6,
    parameter int COL_W     = $clog2(NUM_COLS),
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  scan_mode_t        mode,
    input  logic [COL_W-1:0]  cur_col,
    input  logic [BANK_W-1:0] cur_bank,
    output logic [COL_W-1:0]  nxt_col,
    output logic [BANK_W-1:0] nxt_bank
);
    localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(NUM_COLS - 1);
    localparam logic [BANK_W-1:0] BANK_LAST = BANK_W'(NUM_BANKS - 1);

    logic col_end;
    logic bank_end;
    logic [COL_W-1:0]  col_bumped;
    logic [BANK_W-1:0] bank_bumped;

    always_comb begin
        col_end     = is_last(16'(cur_col), 16'(COL_LAST));
        bank_end    = is_last(16'(cur_bank), 16'(BANK_LAST));
        col_bumped  = COL_W'(wrap_bump(16'(cur_col), 16'(COL_LAST)));
        bank_bumped = BANK_W'(wrap_bump(16'(cur_bank), 16'(BANK_LAST)));
        nxt_col     = cur_col;
        nxt_bank    = cur_bank;
        if (mode == SCAN_HORIZ) begin
            nxt_col = col_bumped;
            if (col_end) nxt_bank = bank_bumped;
        end else begin
            nxt_bank = bank_bumped;
            if (bank_end) nxt_col = col_bumped;
        end
    end

endmodule

// File: rtl/disp_addr_ctr.sv
module disp_addr_ctr
    import disp_addr_pkg::*;
#(
    parameter int NUM_COLS      = 84,
    parameter int NUM_BANKS     = 6,
    parameter int ROWS_PER_BANK = 8,
    parameter int CLAMP_LOADS   = 0,
    parameter int COL_W         = $clog2(NUM_COLS),
    parameter int BANK_W        = $clog2(NUM_BANKS),
    parameter int ROW_W         = $clog2(NUM_BANKS * ROWS_PER_BANK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_wr,
    input  logic              col_ld,
    input  logic [COL_W-1:0]  col_val,
    input  logic              bank_ld,
    input  logic [BANK_W-1:0] bank_val,
    input  logic              mode_ld,
    input  logic              mode_val,
    output logic [COL_W-1:0]  col_ptr,
    output logic [BANK_W-1:0] bank_ptr,
    output logic              vert_mode,
    output logic              wr_en,
    output logic [COL_W-1:0]  wr_col,
    output logic [BANK_W-1:0] wr_bank,
    output logic [ROW_W-1:0]  wr_row
);
    localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(NUM_COLS - 1);
    localparam logic [BANK_W-1:0] BANK_LAST = BANK_W'(NUM_BANKS - 1);

    scan_mode_t        mode_q;
    scan_mode_t        mode_eff;
    logic [COL_W-1:0]  eff_col;
    logic [BANK_W-1:0] eff_bank;
    logic [COL_W-1:0]  nxt_col;
    logic [BANK_W-1:0] nxt_bank;

    assign mode_eff  = mode_ld ? scan_mode_t'(mode_val) : mode_q;
    assign vert_mode = (mode_q == SCAN_VERT);

    dac_load_sel #(
        .NUM_COLS(NUM_COLS), .NUM_BANKS(NUM_BANKS), .CLAMP_LOADS(CLAMP_LOADS),
        .COL_W(COL_W), .BANK_W(BANK_W)
    ) u_load (
        .cur_col(col_ptr), .cur_bank(bank_ptr),
        .col_ld(col_ld), .col_val(col_val),
        .bank_ld(bank_ld), .bank_val(bank_val),
        .eff_col(eff_col), .eff_bank(eff_bank)
    );

    dac_step #(
        .NUM_COLS(NUM_COLS), .NUM_BANKS(NUM_BANKS), .COL_W(COL_W), .BANK_W(BANK_W)
    ) u_step (
        .mode(mode_eff), .cur_col(eff_col), .cur_bank(eff_bank),
        .nxt_col(nxt_col), .nxt_bank(nxt_bank)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= SCAN_HORIZ;
            col_ptr  <= '0;
            bank_ptr <= '0;
            wr_en    <= 1'b0;
            wr_col   <= '0;
            wr_bank  <= '0;
            wr_row   <= '0;
        end else begin
            mode_q   <= mode_eff;
            wr_en    <= byte_wr;
            col_ptr  <= byte_wr ? nxt_col  : eff_col;
            bank_ptr <= byte_wr ? nxt_bank : eff_bank;
            if (byte_wr) begin
                wr_col  <= eff_col;
                wr_bank <= eff_bank;
                wr_row  <= ROW_W'(eff_bank) * ROW_W'(ROWS_PER_BANK);
            end
        end
    end

    // R1
    range_chk: assert property (@(posedge clk) disable iff (rst)
        (col_ptr <= COL_LAST) && (bank_ptr <= BANK_LAST));

    // R2
    horiz_step_chk: assert property (@(posedge clk) disable iff (rst)
        byte_wr && !col_ld && !bank_ld && !mode_ld && (mode_q == SCAN_HORIZ) && (col_ptr != COL_LAST)
        |=> (col_ptr == COL_W'($past(col_ptr) + 1'b1)) && (bank_ptr == $past(bank_ptr)));

    // R3
    vert_step_chk: assert property (@(posedge clk) disable iff (rst)
        byte_wr && !col_ld && !bank_ld && !mode_ld && (mode_q == SCAN_VERT) && (bank_ptr != BANK_LAST)
        |=> (bank_ptr == BANK_W'($past(bank_ptr) + 1'b1)) && (col_ptr == $past(col_ptr)));

    // R4
    last_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        byte_wr && !col_ld && !bank_ld && (col_ptr == COL_LAST) && (bank_ptr == BANK_LAST)
        |=> (col_ptr == '0) && (bank_ptr == '0));

    // R5
    col_only_chk: assert property (@(posedge clk) disable iff (rst)
        col_ld && !bank_ld && !byte_wr |=> $stable(bank_ptr));

    // R6
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (col_ptr == '0) && (bank_ptr == '0) && !vert_mode && !wr_en);

    // R7
    wr_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        byte_wr && !col_ld && !bank_ld
        |=> wr_en && (wr_col == $past(col_ptr)) && (wr_bank == $past(bank_ptr)));

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_ld |=> $stable(vert_mode));

    generate
        if (CLAMP_LOADS == 0) begin : g_oor_chk
            // R9
            oor_ignore_chk: assert property (@(posedge clk) disable iff (rst)
                col_ld && (col_val > COL_LAST) && !byte_wr |=> $stable(col_ptr));
        end
    endgenerate

endmodule

// File: tb/sim_disp_addr_ctr.sv
`timescale 1ns/1ps
module sim_disp_addr_ctr;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byte_wr = 1'b0;
    logic       col_ld = 1'b0;
    logic [6:0] col_val = '0;
    logic       bank_ld = 1'b0;
    logic [2:0] bank_val = '0;
    logic       mode_ld = 1'b0;
    logic       mode_val = 1'b0;
    logic [6:0] col_ptr;
    logic [2:0] bank_ptr;
    logic       vert_mode;
    logic       wr_en;
    logic [6:0] wr_col;
    logic [2:0] wr_bank;
    logic [5:0] wr_row;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    disp_addr_ctr u0 (
        .clk(clk), .rst(rst), .byte_wr(byte_wr),
        .col_ld(col_ld), .col_val(col_val),
        .bank_ld(bank_ld), .bank_val(bank_val),
        .mode_ld(mode_ld), .mode_val(mode_val),
        .col_ptr(col_ptr), .bank_ptr(bank_ptr), .vert_mode(vert_mode),
        .wr_en(wr_en), .wr_col(wr_col), .wr_bank(wr_bank), .wr_row(wr_row)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one cycle of strobes starting at a falling edge, return at the next falling edge.
    task automatic pulse(input bit wr, input bit cl, input int cv, input bit bl, input int bv,
                         input bit ml, input bit mv);
        byte_wr = wr; col_ld = cl; col_val = 7'(cv);
        bank_ld = bl; bank_val = 3'(bv); mode_ld = ml; mode_val = mv;
        @(negedge clk);
        byte_wr = 1'b0; col_ld = 1'b0; bank_ld = 1'b0; mode_ld = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic check_ptr(input string req, input int c, input int b);
        check(req, "col_ptr", int'(col_ptr), c);
        check(req, "bank_ptr", int'(bank_ptr), b);
    endtask

    task automatic t_reset();
        do_reset();
        check_ptr("R6", 0, 0);
        check("R6", "vert_mode", int'(vert_mode), 0);
        check("R6", "wr_en", int'(wr_en), 0);
        @(negedge clk);
        check("R7", "wr_en idle", int'(wr_en), 0);
    endtask

    // Whole-grid walk; linear order index gives the expected write location.
    task automatic t_walk(input bit vert);
        pulse(1'b0, 1'b1, 0, 1'b1, 0, 1'b1, vert);
        check("R10", "vert_mode", int'(vert_mode), int'(vert));
        for (int i = 0; i < 504; i++) begin
            int ec, eb, nc, nb;
            ec = vert ? i / 6 : i % 84;
            eb = vert ? i % 6 : i / 84;
            nc = vert ? ((i + 1) % 504) / 6 : ((i + 1) % 504) % 84;
            nb = vert ? ((i + 1) % 504) % 6 : ((i + 1) % 504) / 84;
            pulse(1'b1, 1'b0, 0, 1'b0, 0, 1'b0, 1'b0);
            check("R7", "wr_en", int'(wr_en), 1);
            check("R7", "wr_col", int'(wr_col), ec);
            check("R7", "wr_bank", int'(wr_bank), eb);
            check("R7", "wr_row", int'(wr_row), eb * 8);
            if (i == 503) check_ptr("R4", nc, nb);
            else if (vert) check_ptr("R3", nc, nb);
            else check_ptr("R2", nc, nb);
            check("R1", "col range", int'(col_ptr < 7'd84), 1);
        end
        @(negedge clk);
        check("R7", "wr_en single", int'(wr_en), 0);
    endtask

    task automatic t_loads();
        pulse(1'b0, 1'b1, 50, 1'b0, 0, 1'b0, 1'b0);
        check_ptr("R5", 50, 0);
        pulse(1'b0, 1'b0, 0, 1'b1, 4, 1'b0, 1'b0);
        check_ptr("R5", 50, 4);
        pulse(1'b0, 1'b1, 7, 1'b1, 1, 1'b0, 1'b0);
        check_ptr("R5", 7, 1);
        pulse(1'b0, 1'b1, 50, 1'b1, 4, 1'b0, 1'b0);
        check_ptr("R5", 50, 4);
    endtask

    task automatic t_out_of_range();
        pulse(1'b0, 1'b1, 84, 1'b0, 0, 1'b0, 1'b0);
        check_ptr("R9", 50, 4);
        pulse(1'b0, 1'b1, 127, 1'b0, 0, 1'b0, 1'b0);
        check_ptr("R9", 50, 4);
        pulse(1'b0, 1'b0, 0, 1'b1, 6, 1'b0, 1'b0);
        check_ptr("R9", 50, 4);
        pulse(1'b0, 1'b0, 0, 1'b1, 7, 1'b0, 1'b0);
        check_ptr("R9", 50, 4);
        pulse(1'b0, 1'b1, 90, 1'b1, 2, 1'b0, 1'b0);
        check_ptr("R9", 50, 2);
        pulse(1'b0, 1'b1, 83, 1'b1, 6, 1'b0, 1'b0);
        check_ptr("R9", 83, 2);
    endtask

    task automatic t_load_with_write();
        // horizontal: load last location and write in one cycle
        pulse(1'b0, 1'b0, 0, 1'b0, 0, 1'b1, 1'b0);
        pulse(1'b1, 1'b1, 83, 1'b1, 5, 1'b0, 1'b0);
        check("R8", "wr_col", int'(wr_col), 83);
        check("R8", "wr_bank", int'(wr_bank), 5);
        check("R8", "wr_row", int'(wr_row), 40);
        check_ptr("R8", 0, 0);
        // column load with write, horizontal
        pulse(1'b1, 1'b1, 20, 1'b0, 0, 1'b0, 1'b0);
        check("R8", "wr_col", int'(wr_col), 20);
        check_ptr("R8", 21, 0);
        // mode switch to vertical and bank load with write
        pulse(1'b1, 1'b0, 0, 1'b1, 5, 1'b1, 1'b1);
        check("R8", "wr_col", int'(wr_col), 21);
        check("R8", "wr_bank", int'(wr_bank), 5);
        check_ptr("R8", 22, 0);
        check("R10", "vert_mode", int'(vert_mode), 1);
        // row base of a middle bank
        pulse(1'b1, 1'b0, 0, 1'b1, 3, 1'b0, 1'b0);
        check("R7", "wr_row", int'(wr_row), 24);
        check_ptr("R3", 22, 4);
        // vertical wrap at last location with a load
        pulse(1'b1, 1'b1, 83, 1'b1, 5, 1'b0, 1'b0);
        check_ptr("R4", 0, 0);
        // mode switch back to horizontal with write
        pulse(1'b1, 1'b0, 0, 1'b0, 0, 1'b1, 1'b0);
        check_ptr("R8", 1, 0);
        check("R10", "vert_mode", int'(vert_mode), 0);
        // mode persists without strobe
        pulse(1'b0, 1'b0, 0, 1'b0, 0, 1'b0, 1'b1);
        check("R10", "vert_mode hold", int'(vert_mode), 0);
    endtask

    task automatic t_reset_midway();
        pulse(1'b0, 1'b1, 40, 1'b1, 3, 1'b1, 1'b1);
        check_ptr("R5", 40, 3);
        byte_wr = 1'b1;
        do_reset();
        byte_wr = 1'b0;
        check_ptr("R6", 0, 0);
        check("R6", "vert_mode", int'(vert_mode), 0);
        check("R6", "wr_en", int'(wr_en), 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_walk(1'b0);
        t_walk(1'b1);
        t_loads();
        t_out_of_range();
        t_load_with_write();
        t_reset_midway();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule